// File: doc/BRIEF.md
# ALU Operand Forwarding Unit

This block sits on the two operand inputs of the ALU in the execute stage of a five-stage in-order pipeline. It resolves read-after-write dependences without a stall. The source register numbers of the execute-stage instruction travel into that stage only so that this block can test them. The block compares them with the destination register of the instructions one and two stages further down the pipe. When it finds a match, it replaces the latched operand with the newer result held in the memory-stage or writeback-stage result register. As a result, dependent ALU instructions can issue back to back.

Each operand has its own three-way selector: latched value, memory-stage result or writeback-stage result. The second operand is never replaced when the execute-stage instruction uses an immediate constant. A load cannot supply data from the memory stage, because its fetched value is not in the memory-stage result register yet. The block is purely combinational and holds no state. The stall logic and the register file belong to the surrounding pipeline.

Producer class codes on `mem_op_i` and `wb_op_i` (3 bits): 0 none, 1 alu, 2 load, 3 address-load, 4 branch-and-link, 5 store, 6 branch, 7 reserved. Select codes on `x_sel_o` and `y_sel_o` (2 bits): 0 latched operand, 1 memory-stage result, 2 writeback-stage result.

Top module: `fwd_unit`

## Requirements
- R1: If `mem_op_i` is 1, 3 or 4 and `mem_rd_i` equals `ex_rs1_i`, then `x_sel_o` is 1 and `x_o` equals `mem_res_i`.
- R2: If R1 does not apply, `wb_op_i` is 1, 2, 3 or 4, and `wb_rd_i` equals `ex_rs1_i`, then `x_sel_o` is 2 and `x_o` equals `wb_res_i`.
- R3: When `ex_imm_i` is 0, the second operand uses the same rules as R1 and R2, comparing `ex_rs2_i` and driving `y_sel_o` and `y_o`.
- R4: When `ex_imm_i` is 1, `y_sel_o` is 0 and `y_o` equals `ex_y_i`, whatever the register fields in the later stages hold.
- R5: When the memory stage and the writeback stage both match the same source, the memory-stage result is selected, because it is the newer value.
- R6: A load (code 2) in the memory stage never forwards. The operand falls through to the writeback-stage check, or to the latched value if that check also fails.
- R7: Store (5), branch (6), none (0) and reserved (7) in either stage never forward, even when their register field matches.
- R8: With no qualifying match, the select is 0 and the operand equals the latched `ex_x_i` or `ex_y_i`. The select codes are never 3.
- R9: The two operands are resolved independently. X and Y may take different sources in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_x_i | input | DATA_W | Latched first operand in execute stage |
| ex_y_i | input | DATA_W | Latched second operand in execute stage |
| ex_rs1_i | input | REG_W | First source register number in execute stage |
| ex_rs2_i | input | REG_W | Second source register number in execute stage |
| ex_imm_i | input | 1 | Execute-stage instruction uses an immediate second operand |
| mem_op_i | input | 3 | Producer class code in memory stage |
| mem_rd_i | input | REG_W | Destination register in memory stage |
| mem_res_i | input | DATA_W | Memory-stage result register |
| wb_op_i | input | 3 | Producer class code in writeback stage |
| wb_rd_i | input | REG_W | Destination register in writeback stage |
| wb_res_i | input | DATA_W | Writeback-stage result register |
| x_o | output | DATA_W | Corrected first ALU operand |
| y_o | output | DATA_W | Corrected second ALU operand |
| x_sel_o | output | 2 | First operand source select |
| y_sel_o | output | 2 | Second operand source select |

## Verification
The bench steps the block through a sequence of stage contents. These cover a single match in each stage, matches in both stages at once, a load sitting in the memory stage with and without a writeback-stage match behind it, and producers that do not write a register but carry a matching field. The both-stage cases separate correct priority from a reversed one. The load cases separate a block that correctly excludes memory-stage loads from one that forwards them, or one that also blocks loads in writeback. Immediate cases with matching register numbers show whether the immediate flag suppresses only Y. Mixed cases, where X and Y take different sources in the same cycle, expose cross-wired selects. Every result register carries a distinct value, so a wrong mux leg shows up in the data as well as in the select.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int unsigned OP_W  = 3;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [OP_W-1:0] {
    OPC_NONE   = 3'd0,
    OPC_ALU    = 3'd1,
    OPC_LOAD   = 3'd2,
    OPC_LADR   = 3'd3,
    OPC_LINK   = 3'd4,
    OPC_STORE  = 3'd5,
    OPC_BRANCH = 3'd6,
    OPC_RSVD   = 3'd7
  } op_class_e;

  typedef enum logic [SEL_W-1:0] {
    SEL_HOLD = 2'd0,
    SEL_MEM  = 2'd1,
    SEL_WB   = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/fwd_producer.sv
// Qualifies a later-stage instruction as a forwarding source.
module fwd_producer
  import fwd_pkg::*;
#(
  parameter bit ALLOW_LOAD = 1'b0
) (
  input  logic [OP_W-1:0] op_i,
  output logic            valid_o
);
  op_class_e op_cls;
  assign op_cls = op_class_e'(op_i);

  always_comb begin
    unique case (op_cls)
      OPC_ALU, OPC_LADR, OPC_LINK: valid_o = 1'b1;
      OPC_LOAD:                    valid_o = ALLOW_LOAD;
      default:                     valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fwd_pick.sv
// Resolves one operand: memory stage outranks writeback stage.
module fwd_pick
  import fwd_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_W  = 5
) (
  input  logic [REG_W-1:0]  src_i,
  input  logic              en_i,
  input  logic [DATA_W-1:0] held_i,
  input  logic              mem_ok_i,
  input  logic [REG_W-1:0]  mem_rd_i,
  input  logic [DATA_W-1:0] mem_res_i,
  input  logic              wb_ok_i,
  input  logic [REG_W-1:0]  wb_rd_i,
  input  logic [DATA_W-1:0] wb_res_i,
  output logic [DATA_W-1:0] opnd_o,
  output logic [SEL_W-1:0]  sel_o
);
  logic     hit_mem, hit_wb;
  fwd_sel_e sel;

  assign hit_mem = en_i && mem_ok_i && (mem_rd_i == src_i);
  assign hit_wb  = en_i && wb_ok_i  && (wb_rd_i  == src_i);

  always_comb begin
    if (hit_mem)     sel = SEL_MEM;
    else if (hit_wb) sel = SEL_WB;
    else             sel = SEL_HOLD;
  end

  always_comb begin
    unique case (sel)
      SEL_MEM: opnd_o = mem_res_i;
      SEL_WB:  opnd_o = wb_res_i;
      default: opnd_o = held_i;
    endcase
  end

  assign sel_o = sel;
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_W  = 5
) (
  input  logic [DATA_W-1:0] ex_x_i,
  input  logic [DATA_W-1:0] ex_y_i,
  input  logic [REG_W-1:0]  ex_rs1_i,
  input  logic [REG_W-1:0]  ex_rs2_i,
  input  logic              ex_imm_i,
  input  logic [2:0]        mem_op_i,
  input  logic [REG_W-1:0]  mem_rd_i,
  input  logic [DATA_W-1:0] mem_res_i,
  input  logic [2:0]        wb_op_i,
  input  logic [REG_W-1:0]  wb_rd_i,
  input  logic [DATA_W-1:0] wb_res_i,
  output logic [DATA_W-1:0] x_o,
  output logic [DATA_W-1:0] y_o,
  output logic [1:0]        x_sel_o,
  output logic [1:0]        y_sel_o
);
  localparam int unsigned N_OPND = 2;

  logic mem_ok, wb_ok;

  // load data only exists after the memory stage
  fwd_producer #(.ALLOW_LOAD(1'b0)) u_prod_mem (.op_i(mem_op_i), .valid_o(mem_ok));
  fwd_producer #(.ALLOW_LOAD(1'b1)) u_prod_wb  (.op_i(wb_op_i),  .valid_o(wb_ok));

  logic [REG_W-1:0]  src   [N_OPND];
  logic              en    [N_OPND];
  logic [DATA_W-1:0] held  [N_OPND];
  logic [DATA_W-1:0] opnd  [N_OPND];
  logic [SEL_W-1:0]  sel   [N_OPND];

  assign src[0]  = ex_rs1_i;
  assign en[0]   = 1'b1;
  assign held[0] = ex_x_i;
  assign src[1]  = ex_rs2_i;
  assign en[1]   = !ex_imm_i;
  assign held[1] = ex_y_i;

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    fwd_pick #(.DATA_W(DATA_W), .REG_W(REG_W)) u_pick (
      .src_i    (src[g]),
      .en_i     (en[g]),
      .held_i   (held[g]),
      .mem_ok_i (mem_ok),
      .mem_rd_i (mem_rd_i),
      .mem_res_i(mem_res_i),
      .wb_ok_i  (wb_ok),
      .wb_rd_i  (wb_rd_i),
      .wb_res_i (wb_res_i),
      .opnd_o   (opnd[g]),
      .sel_o    (sel[g])
    );
  end

  assign x_o     = opnd[0];
  assign y_o     = opnd[1];
  assign x_sel_o = sel[0];
  assign y_sel_o = sel[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_W  = 5
) (
  input logic [DATA_W-1:0] ex_x_i,
  input logic [DATA_W-1:0] ex_y_i,
  input logic [REG_W-1:0]  ex_rs1_i,
  input logic [REG_W-1:0]  ex_rs2_i,
  input logic              ex_imm_i,
  input logic [2:0]        mem_op_i,
  input logic [REG_W-1:0]  mem_rd_i,
  input logic [DATA_W-1:0] mem_res_i,
  input logic [2:0]        wb_op_i,
  input logic [REG_W-1:0]  wb_rd_i,
  input logic [DATA_W-1:0] wb_res_i,
  input logic [DATA_W-1:0] x_o,
  input logic [DATA_W-1:0] y_o,
  input logic [1:0]        x_sel_o,
  input logic [1:0]        y_sel_o
);
  logic mem_wr, wb_wr;
  assign mem_wr = (mem_op_i == 3'd1) || (mem_op_i == 3'd3) || (mem_op_i == 3'd4);
  assign wb_wr  = mem_wr_like(wb_op_i);

  function automatic logic mem_wr_like(input logic [2:0] op);
    return (op == 3'd1) || (op == 3'd2) || (op == 3'd3) || (op == 3'd4);
  endfunction

  always_comb begin
    assert_x_mem_R1: assert (x_sel_o != 2'd1 ||
      (x_o == mem_res_i && mem_wr && mem_rd_i == ex_rs1_i));
    assert_x_wb_R2: assert (x_sel_o != 2'd2 ||
      (x_o == wb_res_i && wb_wr && wb_rd_i == ex_rs1_i));
    assert_y_fwd_R3: assert (y_sel_o == 2'd0 ||
      (y_o == (y_sel_o == 2'd1 ? mem_res_i : wb_res_i) && !ex_imm_i));
    assert_imm_hold_R4: assert (!ex_imm_i || (y_sel_o == 2'd0 && y_o == ex_y_i));
    assert_mem_first_R5: assert (!(mem_wr && mem_rd_i == ex_rs1_i) || x_sel_o == 2'd1);
    assert_no_load_mem_R6: assert (mem_op_i != 3'd2 || (x_sel_o != 2'd1 && y_sel_o != 2'd1));
    assert_sel_legal_R8: assert (x_sel_o != 2'd3 && y_sel_o != 2'd3);
    assert_x_hold_R8: assert (x_sel_o != 2'd0 || x_o == ex_x_i);
  end
endmodule

bind fwd_unit fwd_unit_chk #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (.*);

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned REG_W   = 5;
  localparam time         CLK_PER = 10ns;
  localparam int unsigned WD_MAX  = 5000;

  logic clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  logic [DATA_W-1:0] ex_x, ex_y, mem_res, wb_res, x_o, y_o;
  logic [REG_W-1:0]  rs1, rs2, mem_rd, wb_rd;
  logic              imm;
  logic [2:0]        mem_op, wb_op;
  logic [1:0]        x_sel, y_sel;

  fwd_unit #(.DATA_W(DATA_W), .REG_W(REG_W)) u_dut (
    .ex_x_i(ex_x), .ex_y_i(ex_y), .ex_rs1_i(rs1), .ex_rs2_i(rs2), .ex_imm_i(imm),
    .mem_op_i(mem_op), .mem_rd_i(mem_rd), .mem_res_i(mem_res),
    .wb_op_i(wb_op), .wb_rd_i(wb_rd), .wb_res_i(wb_res),
    .x_o(x_o), .y_o(y_o), .x_sel_o(x_sel), .y_sel_o(y_sel)
  );

  typedef struct {
    logic [DATA_W-1:0] x;
    logic [DATA_W-1:0] y;
    logic [1:0]        xs;
    logic [1:0]        ys;
    string             tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  int   n_case = 0;
  bit   done = 1'b0;

  function automatic logic [DATA_W-1:0] pick(input logic [1:0] s, input logic [DATA_W-1:0] h,
                                             input logic [DATA_W-1:0] m, input logic [DATA_W-1:0] w);
    return (s == 2'd1) ? m : (s == 2'd2) ? w : h;
  endfunction

  task automatic drive(input logic [2:0] op4, input logic [REG_W-1:0] rd4,
                       input logic [2:0] op5, input logic [REG_W-1:0] rd5,
                       input logic [REG_W-1:0] s1, input logic [REG_W-1:0] s2,
                       input logic im, input logic [1:0] exs, input logic [1:0] eys,
                       input string tag);
    exp_t e;
    @(negedge clk);
    n_case++;
    ex_x    = 32'h1100_0000 + n_case;
    ex_y    = 32'h2200_0000 + n_case;
    mem_res = 32'h4400_0000 + n_case;
    wb_res  = 32'h5500_0000 + n_case;
    mem_op = op4; mem_rd = rd4; wb_op = op5; wb_rd = rd5;
    rs1 = s1; rs2 = s2; imm = im;
    e.xs = exs; e.ys = eys; e.tag = tag;
    e.x = pick(exs, ex_x, mem_res, wb_res);
    e.y = pick(eys, ex_y, mem_res, wb_res);
    exp_q.push_back(e);
  endtask

  always @(posedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_cmp++;
      if (x_sel !== e.xs || x_o !== e.x || y_sel !== e.ys || y_o !== e.y) begin
        n_bad++;
        $display("FAIL %s: x_sel=%0d x=%h y_sel=%0d y=%h expected x_sel=%0d x=%h y_sel=%0d y=%h",
                 e.tag, x_sel, x_o, y_sel, y_o, e.xs, e.x, e.ys, e.y);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WD_MAX) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // idle pipe: latched operands pass
    drive(3'd0, 5'd0, 3'd0, 5'd0, 5'd0, 5'd0, 1'b0, 2'd0, 2'd0, "R8 idle");
    drive(3'd1, 5'd3, 3'd0, 5'd0, 5'd3, 5'd7, 1'b0, 2'd1, 2'd0, "R1 alu mem to X");
    drive(3'd1, 5'd7, 3'd0, 5'd0, 5'd3, 5'd7, 1'b0, 2'd0, 2'd1, "R3 alu mem to Y");
    drive(3'd1, 5'd7, 3'd0, 5'd0, 5'd3, 5'd7, 1'b1, 2'd0, 2'd0, "R4 imm blocks Y");
    drive(3'd0, 5'd0, 3'd2, 5'd3, 5'd3, 5'd8, 1'b0, 2'd2, 2'd0, "R2 load wb to X");
    drive(3'd1, 5'd3, 3'd1, 5'd3, 5'd3, 5'd3, 1'b0, 2'd1, 2'd1, "R5 both stages");
    drive(3'd2, 5'd3, 3'd0, 5'd3, 5'd3, 5'd9, 1'b0, 2'd0, 2'd0, "R6 load mem no fwd");
    drive(3'd2, 5'd3, 3'd1, 5'd3, 5'd3, 5'd9, 1'b0, 2'd2, 2'd0, "R6 load mem falls to wb");
    drive(3'd5, 5'd3, 3'd6, 5'd4, 5'd3, 5'd4, 1'b0, 2'd0, 2'd0, "R7 store/branch");
    drive(3'd3, 5'd2, 3'd4, 5'd9, 5'd2, 5'd9, 1'b0, 2'd1, 2'd2, "R9 ladr X link Y");
    drive(3'd4, 5'd5, 3'd1, 5'd6, 5'd6, 5'd5, 1'b0, 2'd2, 2'd1, "R9 wb X mem Y");
    drive(3'd0, 5'd3, 3'd5, 5'd3, 5'd3, 5'd3, 1'b0, 2'd0, 2'd0, "R7 none/store match");
    drive(3'd7, 5'd3, 3'd7, 5'd3, 5'd3, 5'd3, 1'b0, 2'd0, 2'd0, "R7 reserved");
    drive(3'd1, 5'd1, 3'd1, 5'd4, 5'd2, 5'd3, 1'b0, 2'd0, 2'd0, "R8 no match");
    drive(3'd0, 5'd0, 3'd1, 5'd12, 5'd1, 5'd12, 1'b1, 2'd0, 2'd0, "R4 imm blocks wb");
    drive(3'd1, 5'd12, 3'd3, 5'd12, 5'd12, 5'd0, 1'b1, 2'd1, 2'd0, "R5 X mem over wb imm");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule